// File: doc/BRIEF.md
# Serial-bus EEPROM slave with write-once page and read-only window

This block is the logic of a two-wire serial memory slave, clocked by a fast system clock that oversamples the bus lines SCL and SDA. It detects START and STOP, checks the device-select byte, takes a two-byte address and serves one of three regions. The regions are a main array of 4096 bytes, a separate 32-byte page that can be written only once, and a small control register. The control register sets how much of the top of the main array is read-only. The memories are internal arrays. The slave pulls SDA low through `sda_oe` and never drives it high.

Writes go straight into the selected array as each data byte is acknowledged. A page write stays inside its aligned 32-byte page. Reads may be current, random or sequential, and a sequential read rolls over inside the region being read. Two input pins veto writes: one covers the array and the page, the other covers the control register. When at least one byte has been stored, STOP starts a fixed-length programming interval. During that interval every select byte is refused.

Top module: `eep_slave`

## Requirements
- R1: After reset the slave leaves SDA released, every byte of the main array and the write-once page reads FFh, and the control register reads 00h.
- R2: A select byte is acknowledged (SDA held low on the ninth clock) only if its upper nibble is 1010 and bits 3:1 are 000 (main array), 001 (write-once page) or 100 (control register). Bit 0 is 1 for a read. Any other select byte gets no acknowledge.
- R3: A write-direction select is followed by two acknowledged address bytes: the low four bits of the first give address bits 11:8 and the second gives bits 7:0. The data bytes that follow are stored there. A random read (address phase, repeated START, read select) returns the byte at that address, and a current read continues from the address after the last byte transferred.
- R4: Successive data bytes of one write go to successive addresses with bits 4:0 wrapping, so bits 11:5 stay fixed, and bytes outside that 32-byte page are left unchanged.
- R5: A sequential read returns successive bytes while the master acknowledges. It rolls from 0xFFF to 0x000 in the main array and from 31 to 0 in the write-once page.
- R6: Once a transaction that stored data into the write-once page has ended with STOP, later writes to the page are acknowledged but leave its contents unchanged.
- R7: A control value N (bits 2:0 of the byte written) makes main-array addresses whose bits 11:10 are at least 4-N read-only: N=0 protects nothing, N=2 protects 0x800-0xFFF, N of 4 or more protects everything. Writes there are acknowledged and dropped. The register reads back as N.
- R8: With `wc` high, data bytes to the main array and the page are acknowledged and dropped. With `wcr` high, the same applies to the control register.
- R9: After STOP ends a transaction that stored at least one byte, every select byte is refused for PROG_CYC clocks. A transaction whose writes were all dropped starts no such interval.
- R10: The slave changes SDA only while SCL is low. After the master does not acknowledge a read byte, the slave keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wc | input | 1 | High vetoes writes to main array and write-once page |
| wcr | input | 1 | High vetoes writes to the control register |

## Verification
A wrong bit counter or state shows within one byte time as a missing or misplaced acknowledge on the ninth clock, or as read data shifted by one bit. Wrong address or wrap logic stays hidden until a later read of a neighbouring location returns a byte that should not be there. For that reason every write scenario is followed by a read of the written bytes and of the bytes just outside them. A lock, window or busy fault is caught by probing the next transaction right after STOP. There it shows as an acknowledge that should have been refused, or as stale data in the following read.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_AHI,
        S_ALO,
        S_WR,
        S_RD
    } st_e;

    typedef enum logic [1:0] {
        RG_MAIN,
        RG_OTP,
        RG_CTRL
    } rg_e;

    localparam logic [3:0] DEV_ID   = 4'b1010;
    localparam logic [2:0] SEL_MAIN = 3'b000;
    localparam logic [2:0] SEL_OTP  = 3'b001;
    localparam logic [2:0] SEL_CTRL = 3'b100;

endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense #(
    parameter int STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv_q;

    assign raw = {scl_in, sda_in};

    // one synchronizer chain per bus line; idle level is high
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STG-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STG-2:0], raw[g]};
        end
        assign cur[g] = chain_q[STG-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv_q <= '1;
        else        prv_q <= cur;
    end

    assign sda_s    = cur[0];
    assign ev_rise  =  cur[1] & ~prv_q[1];
    assign ev_fall  = ~cur[1] &  prv_q[1];
    assign ev_start =  cur[1] &  prv_q[1] &  prv_q[0] & ~cur[0];
    assign ev_stop  =  cur[1] &  prv_q[1] & ~prv_q[0] &  cur[0];
endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5,
    parameter int CTRL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rg_e               rg,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [7:0]        wdata,
    input  logic              we,
    output logic [CTRL_W-1:0] ctrl_n,
    output logic [7:0]        rdata
);
    localparam int MAIN_N = 1 << ADDR_W;
    localparam int OTP_N  = 1 << PAGE_W;

    logic [7:0]        main_q [MAIN_N];
    logic [7:0]        otp_q  [OTP_N];
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_N; i++) main_q[i] <= 8'hFF;
            for (int i = 0; i < OTP_N; i++)  otp_q[i]  <= 8'hFF;
            ctrl_q <= '0;
        end else if (we) begin
            case (rg)
                RG_MAIN: main_q[ptr]               <= wdata;
                RG_OTP:  otp_q[ptr[PAGE_W-1:0]]    <= wdata;
                RG_CTRL: ctrl_q                    <= wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rg)
            RG_MAIN: rdata = main_q[ptr];
            RG_OTP:  rdata = otp_q[ptr[PAGE_W-1:0]];
            RG_CTRL: rdata = {{(8-CTRL_W){1'b0}}, ctrl_q};
            default: rdata = 8'hFF;
        endcase
    end

    assign ctrl_n = ctrl_q;
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PAGE_W   = 5,
    parameter int CTRL_W   = 3,
    parameter int SYNC_STG = 2,
    parameter int PROG_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic wc,
    input  logic wcr
);
    localparam int CNT_W = $clog2(PROG_CYC + 1);

    typedef struct packed {
        st_e               st;
        st_e               nst;
        rg_e               rg;
        logic [3:0]        bitc;
        logic              in_ack;
        logic              ack;
        logic              mack;
        logic              oe;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              wrote;
        logic              wrote_otp;
        logic              otp_lock;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t r_q, r_d;

    logic              sda_s, ev_rise, ev_fall, ev_start, ev_stop;
    logic [CTRL_W-1:0] ctrl_n;
    logic [7:0]        rdata, byte_in;
    logic              we, load, win, allow;

    eep_line_sense #(.STG(SYNC_STG)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
        .ev_start(ev_start), .ev_stop(ev_stop)
    );

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CTRL_W(CTRL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rg(r_q.rg), .ptr(r_q.ptr), .wdata(byte_in),
        .we(we), .ctrl_n(ctrl_n), .rdata(rdata)
    );

    function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] p);
        return {p[ADDR_W-1:PAGE_W], PAGE_W'(p[PAGE_W-1:0] + 1'b1)};
    endfunction

    function automatic logic [ADDR_W-1:0] read_inc(input logic [ADDR_W-1:0] p, input rg_e g);
        case (g)
            RG_MAIN: return p + 1'b1;
            RG_OTP:  return page_inc(p);
            default: return p;
        endcase
    endfunction

    always_comb begin
        r_d     = r_q;
        we      = 1'b0;
        load    = 1'b0;
        byte_in = {r_q.sh[6:0], sda_s};
        // read-only window: top blocks of a quarter of the array each
        win = ({2'b00, r_q.ptr[ADDR_W-1 -: 2]} + 4'(ctrl_n)) >= 4'd4;
        case (r_q.rg)
            RG_MAIN: allow = !wc && !win;
            RG_OTP:  allow = !wc && !r_q.otp_lock;
            default: allow = !wcr;
        endcase

        if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;

        if (ev_stop) begin
            r_d.st     = S_IDLE;
            r_d.oe     = 1'b0;
            r_d.in_ack = 1'b0;
            r_d.bitc   = '0;
            if (r_q.wrote) r_d.cnt = CNT_W'(PROG_CYC);
            if (r_q.wrote_otp) r_d.otp_lock = 1'b1;
            r_d.wrote     = 1'b0;
            r_d.wrote_otp = 1'b0;
        end else if (ev_start) begin
            r_d.st     = S_DEV;
            r_d.oe     = 1'b0;
            r_d.in_ack = 1'b0;
            r_d.bitc   = '0;
        end else if (r_q.st == S_RD) begin
            if (ev_rise) begin
                if (r_q.in_ack)           r_d.mack = !sda_s;
                else if (r_q.bitc < 4'd8) r_d.bitc = r_q.bitc + 1'b1;
            end else if (ev_fall) begin
                if (r_q.in_ack) begin
                    r_d.in_ack = 1'b0;
                    if (r_q.mack) load = 1'b1;
                    else begin
                        r_d.st = S_IDLE;
                        r_d.oe = 1'b0;
                    end
                end else if (r_q.bitc == 4'd8) begin
                    r_d.in_ack = 1'b1;
                    r_d.oe     = 1'b0;
                end else if (r_q.bitc != '0) begin
                    r_d.oe = !r_q.sh[6];
                    r_d.sh = {r_q.sh[6:0], 1'b0};
                end
            end
        end else if (r_q.st != S_IDLE) begin
            if (ev_rise && !r_q.in_ack && r_q.bitc < 4'd8) begin
                r_d.sh   = byte_in;
                r_d.bitc = r_q.bitc + 1'b1;
                if (r_q.bitc == 4'd7) begin
                    r_d.ack = 1'b1;
                    case (r_q.st)
                        S_DEV: begin
                            r_d.ack = (byte_in[7:4] == DEV_ID) && (r_q.cnt == '0) &&
                                      (byte_in[3:1] == SEL_MAIN || byte_in[3:1] == SEL_OTP ||
                                       byte_in[3:1] == SEL_CTRL);
                            case (byte_in[3:1])
                                SEL_OTP:  r_d.rg = RG_OTP;
                                SEL_CTRL: r_d.rg = RG_CTRL;
                                default:  r_d.rg = RG_MAIN;
                            endcase
                            r_d.nst = byte_in[0] ? S_RD : S_AHI;
                        end
                        S_AHI: begin
                            r_d.ptr[ADDR_W-1:8] = byte_in[ADDR_W-9:0];
                            r_d.nst = S_ALO;
                        end
                        S_ALO: begin
                            r_d.ptr[7:0] = byte_in;
                            r_d.nst = S_WR;
                        end
                        default: begin
                            if (allow) begin
                                we        = 1'b1;
                                r_d.wrote = 1'b1;
                                if (r_q.rg == RG_OTP) r_d.wrote_otp = 1'b1;
                            end
                            r_d.ptr = page_inc(r_q.ptr);
                            r_d.nst = S_WR;
                        end
                    endcase
                end
            end else if (ev_fall) begin
                if (r_q.in_ack) begin
                    r_d.in_ack = 1'b0;
                    r_d.oe     = 1'b0;
                    r_d.bitc   = '0;
                    if (!r_q.ack) r_d.st = S_IDLE;
                    else begin
                        r_d.st = r_q.nst;
                        if (r_q.nst == S_RD) load = 1'b1;
                    end
                end else if (r_q.bitc == 4'd8) begin
                    r_d.in_ack = 1'b1;
                    r_d.oe     = r_q.ack;
                end
            end
        end

        if (load) begin
            r_d.sh   = rdata;
            r_d.oe   = !rdata[7];
            r_d.ptr  = read_inc(r_q.ptr, r_q.rg);
            r_d.bitc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe = r_q.oe;

    // SDA drive moves only on a detected SCL fall or a bus condition
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.oe != $past(r_q.oe)) |-> $past(ev_fall || ev_start || ev_stop));

    // nothing drives the line while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE) |-> !r_q.oe);

    // a select byte seen during programming is never acknowledged
    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DEV && r_q.cnt != '0) |-> !r_q.oe);

    // a stored data byte never moves the pointer out of its page
    p_page_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && r_q.st == S_WR) |=> $stable(r_q.ptr[ADDR_W-1:PAGE_W]));

    // the page lock never clears
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(r_q.otp_lock));

    // the array veto pin blocks every store outside the control register
    p_wc_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wc) |-> (r_q.rg == RG_CTRL));

    // bit counter stays within one byte plus acknowledge
    p_bitc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bitc <= 4'd8);
endmodule

// File: tb/test_eep_slave.sv
`timescale 1ns/1ps
module test_eep_slave;
    localparam int Q    = 5;
    localparam int PROG = 600;
    localparam logic [2:0] RM = 3'b000, RO = 3'b001, RC = 3'b100;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wc = 1'b0, wcr = 1'b0;
    logic sda_oe, sda_line;
    int   n_chk = 0, n_bad = 0, n_glitch = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic       all_ack;

    assign sda_line = sda_m & ~sda_oe;
    always #2.5 clk = ~clk;

    eep_slave #(.PROG_CYC(PROG)) i_eep_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .wc(wc), .wcr(wcr)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] selb(input logic [2:0] rs, input logic rd);
        return {4'b1010, rs, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q); scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
        end
        sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q);
        ackd = !sda_line;
        hold(Q); scl = 1'b0; hold(Q);
    endtask

    task automatic get_byte(input logic last, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q); scl = 1'b1; hold(Q); b[i] = sda_line; hold(Q);
            if (sda_line !== b[i]) n_glitch++;
            scl = 1'b0; hold(Q);
        end
        sda_m = last; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
        sda_m = 1'b1;
    endtask

    task automatic probe(input logic [7:0] b, output logic a);
        bus_start(); put_byte(b, a); bus_stop();
    endtask

    task automatic addr_phase(input logic [2:0] rs, input logic [11:0] a);
        logic k;
        bus_start();
        put_byte(selb(rs, 1'b0), k); all_ack = k;
        put_byte({4'h0, a[11:8]}, k); all_ack &= k;
        put_byte(a[7:0], k);          all_ack &= k;
    endtask

    task automatic wr_seq(input logic [2:0] rs, input logic [11:0] a, input int n);
        logic k;
        addr_phase(rs, a);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], k); all_ack &= k;
        end
        bus_stop();
    endtask

    task automatic rd_seq(input logic [2:0] rs, input logic [11:0] a, input int n);
        logic k;
        logic [7:0] b;
        addr_phase(rs, a);
        bus_start();
        put_byte(selb(rs, 1'b1), k); all_ack &= k;
        for (int i = 0; i < n; i++) begin
            get_byte(i == n - 1, b); rbuf[i] = b;
        end
        hold(Q);
        chk(sda_line == 1'b1, "R10 released after master NACK", int'(sda_line), 1);
        bus_stop();
    endtask

    task automatic cur_rd(input logic [2:0] rs, output logic [7:0] b);
        logic k;
        bus_start(); put_byte(selb(rs, 1'b1), k); get_byte(1'b1, b); bus_stop();
    endtask

    task automatic wait_prog();
        hold(PROG + 20);
    endtask

    task automatic t_reset();
        chk(sda_line == 1'b1, "R1 SDA released after reset", int'(sda_line), 1);
        rd_seq(RM, 12'h123, 1);
        chk(rbuf[0] == 8'hFF, "R1 main array erased", rbuf[0], 8'hFF);
        rd_seq(RO, 12'h000, 1);
        chk(rbuf[0] == 8'hFF, "R1 write-once page erased", rbuf[0], 8'hFF);
        rd_seq(RC, 12'h000, 1);
        chk(rbuf[0] == 8'h00, "R1 control register zero", rbuf[0], 0);
    endtask

    task automatic t_select();
        logic a;
        probe(8'hA0, a); chk(a, "R2 main select acked", a, 1);
        probe(8'hA2, a); chk(a, "R2 page select acked", a, 1);
        probe(8'hA8, a); chk(a, "R2 control select acked", a, 1);
        probe(8'hA4, a); chk(!a, "R2 region 010 refused", a, 0);
        probe(8'hA6, a); chk(!a, "R2 region 011 refused", a, 0);
        probe(8'hB0, a); chk(!a, "R2 wrong id refused", a, 0);
    endtask

    task automatic t_byte();
        logic a;
        wbuf[0] = 8'h5A;
        wr_seq(RM, 12'h123, 1);
        chk(all_ack, "R3 byte write acked", all_ack, 1);
        probe(8'hA0, a); chk(!a, "R9 select refused while programming", a, 0);
        wait_prog();
        probe(8'hA0, a); chk(a, "R9 select acked after programming", a, 1);
        rd_seq(RM, 12'h123, 1);
        chk(rbuf[0] == 8'h5A, "R3 random read of written byte", rbuf[0], 8'h5A);
    endtask

    task automatic t_page();
        logic [7:0] b;
        for (int i = 0; i < 5; i++) wbuf[i] = 8'hA0 + 8'(i);
        wr_seq(RM, 12'h03E, 5);
        wait_prog();
        rd_seq(RM, 12'h020, 2);
        chk(rbuf[0] == 8'hA2, "R4 wrap to page start", rbuf[0], 8'hA2);
        chk(rbuf[1] == 8'hA3, "R4 wrap second byte", rbuf[1], 8'hA3);
        cur_rd(RM, b);
        chk(b == 8'hA4, "R3 current read continues", b, 8'hA4);
        rd_seq(RM, 12'h03E, 2);
        chk(rbuf[0] == 8'hA0 && rbuf[1] == 8'hA1, "R4 page tail bytes", {rbuf[0], rbuf[1]}, 16'hA0A1);
        rd_seq(RM, 12'h040, 1);
        chk(rbuf[0] == 8'hFF, "R4 next page untouched", rbuf[0], 8'hFF);
    endtask

    task automatic t_roll();
        wbuf[0] = 8'h11; wr_seq(RM, 12'hFFF, 1); wait_prog();
        wbuf[0] = 8'h22; wr_seq(RM, 12'h000, 1); wait_prog();
        rd_seq(RM, 12'hFFF, 2);
        chk(rbuf[0] == 8'h11 && rbuf[1] == 8'h22, "R5 main rollover", {rbuf[0], rbuf[1]}, 16'h1122);
    endtask

    task automatic t_otp();
        logic a;
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        wr_seq(RO, 12'h01F, 2); wait_prog();
        rd_seq(RO, 12'h01F, 2);
        chk(rbuf[0] == 8'hC3 && rbuf[1] == 8'h3C, "R5 page rollover", {rbuf[0], rbuf[1]}, 16'hC33C);
        wbuf[0] = 8'h77;
        wr_seq(RO, 12'h005, 1);
        chk(all_ack, "R6 locked write still acked", all_ack, 1);
        probe(8'hA2, a); chk(a, "R9 dropped write starts no cycle", a, 1);
        rd_seq(RO, 12'h005, 1);
        chk(rbuf[0] == 8'hFF, "R6 locked page unchanged", rbuf[0], 8'hFF);
        rd_seq(RO, 12'h01F, 1);
        chk(rbuf[0] == 8'hC3, "R6 first write kept", rbuf[0], 8'hC3);
    endtask

    task automatic t_pins();
        logic a;
        wc = 1'b1;
        wbuf[0] = 8'h99; wr_seq(RM, 12'h200, 1);
        chk(all_ack, "R8 vetoed data acked", all_ack, 1);
        probe(8'hA0, a); chk(a, "R9 vetoed write starts no cycle", a, 1);
        wc = 1'b0;
        rd_seq(RM, 12'h200, 1);
        chk(rbuf[0] == 8'hFF, "R8 wc drops main write", rbuf[0], 8'hFF);
        wcr = 1'b1;
        wbuf[0] = 8'h02; wr_seq(RC, 12'h000, 1);
        wcr = 1'b0;
        rd_seq(RC, 12'h000, 1);
        chk(rbuf[0] == 8'h00, "R8 wcr drops control write", rbuf[0], 0);
    endtask

    task automatic t_window();
        wbuf[0] = 8'h02; wr_seq(RC, 12'h000, 1); wait_prog();
        rd_seq(RC, 12'h000, 1);
        chk(rbuf[0] == 8'h02, "R7 control reads back N", rbuf[0], 8'h02);
        wbuf[0] = 8'h44; wr_seq(RM, 12'h800, 1);
        chk(all_ack, "R7 protected write acked", all_ack, 1);
        rd_seq(RM, 12'h800, 1);
        chk(rbuf[0] == 8'hFF, "R7 window bottom protected", rbuf[0], 8'hFF);
        wr_seq(RM, 12'h7FF, 1); wait_prog();
        rd_seq(RM, 12'h7FF, 1);
        chk(rbuf[0] == 8'h44, "R7 below window writable", rbuf[0], 8'h44);
        wbuf[0] = 8'h04; wr_seq(RC, 12'h000, 1); wait_prog();
        wbuf[0] = 8'h55; wr_seq(RM, 12'h000, 1);
        rd_seq(RM, 12'h000, 1);
        chk(rbuf[0] == 8'h22, "R7 N=4 protects all", rbuf[0], 8'h22);
        wbuf[0] = 8'h00; wr_seq(RC, 12'h000, 1); wait_prog();
        wbuf[0] = 8'h66; wr_seq(RM, 12'hC00, 1); wait_prog();
        rd_seq(RM, 12'hC00, 1);
        chk(rbuf[0] == 8'h66, "R7 N=0 protects nothing", rbuf[0], 8'h66);
    endtask

    initial begin
        hold(10); rst_n = 1'b1; hold(10);
        t_reset();
        t_select();
        t_byte();
        t_page();
        t_roll();
        t_otp();
        t_pins();
        t_window();
        chk(n_glitch == 0, "R10 SDA stable while SCL high", n_glitch, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements) act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule